// File: doc/BRIEF.md
# Digital Trigger Source Conditioner

This block takes two raw digital trigger lines, a front-panel I/O line and a backplane trigger line, and brings both into the system clock domain. It chooses one of them and turns it into the trigger that an acquisition controller consumes. The chosen line can be aligned to a 10 MHz reference: in that case it is resampled only on the system-clock cycles marked by a reference enable. The backplane line is always aligned this way. The front-panel line is aligned only when the alignment bit asks for it.

A 3-bit behaviour code decides what the output means. Two codes are levels: the output follows the line, or follows its inverse, for as long as the condition holds. Two codes are edges: the output gives a one-cycle pulse on each rising or each falling transition. All other codes disable the output.

Edge detection is done by a small state machine that remembers the last level of the line. It has three states. ST_OFF means no behaviour is armed. ST_LOW means the line was last seen low. ST_HIGH means the line was last seen high. Its transitions are as follows:
- arm: ST_OFF goes to ST_LOW or ST_HIGH, matching the line, when a valid code is applied.
- rise: ST_LOW goes to ST_HIGH.
- fall: ST_HIGH goes to ST_LOW.
- disarm: any state goes back to ST_OFF when the code becomes invalid.

Top module: `trig_cond`

## Requirements
- R1: `src_sel` = 0 routes the front-panel line (`io_line`) to the trigger logic. `src_sel` = 1 routes the backplane line (`bp_line`). The unselected line has no effect on `trig_out`.
- R2: On the unaligned front-panel path (`src_sel` = 0, `io_align` = 0), a change on `io_line` reaches `trig_out` on the third rising clock edge after the change. Two of these edges are synchroniser stages and one is the output register.
- R3: On the backplane path, the conditioned line takes a new value only on a clock edge at which `ref_tick` was high, whatever the value of `io_align`.
- R4: On the front-panel path with `io_align` = 1, the conditioned line takes a new value only on a clock edge at which `ref_tick` was high. When `ref_tick` is high in the same cycle that the synchronised value first changes, that value is taken at that edge and appears on `trig_out` one edge later.
- R5: With `behav` = 3'b001, `trig_out` is high while the conditioned line is high.
- R6: With `behav` = 3'b010, `trig_out` is high while the conditioned line is low.
- R7: With `behav` = 3'b011, each low-to-high transition of the conditioned line gives exactly one cycle of `trig_out` high. A falling transition gives no pulse.
- R8: With `behav` = 3'b100, each high-to-low transition gives exactly one cycle of `trig_out` high. A rising transition gives no pulse.
- R9: With `behav` equal to 3'b000, 3'b101, 3'b110 or 3'b111, `trig_out` stays low whatever the lines do.
- R10: While `rst_n` is low, `trig_out` is low. An edge code applied directly after a disabled code gives no pulse for the level already present on the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_line | input | 1 | Raw front-panel trigger line, asynchronous |
| bp_line | input | 1 | Raw backplane trigger line, asynchronous |
| ref_tick | input | 1 | One-cycle enable marking each 10 MHz reference tick |
| src_sel | input | 1 | Source select: 0 front-panel, 1 backplane |
| io_align | input | 1 | Align the front-panel line to `ref_tick` |
| behav | input | 3 | Behaviour code: 1 level high, 2 level low, 3 rising edge, 4 falling edge, others disabled |
| trig_out | output | 1 | Conditioned trigger level or pulse |

## Verification
Two events can land in the same cycle on an aligned path. A reference tick can arrive in exactly the cycle in which the synchronised line first shows its new value. That new value then has to be taken at that edge, not one tick later. The bench provokes this by holding the free-running tick off, changing the line, and forcing a single `ref_tick` into the cycle after the second synchroniser edge. It judges the result by requiring `trig_out` to be still low after the capture edge and high exactly one edge later.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;

    localparam int BEHAV_W = 3;

    localparam logic [BEHAV_W-1:0] BH_OFF    = 3'd0;
    localparam logic [BEHAV_W-1:0] BH_LVL_HI = 3'd1;
    localparam logic [BEHAV_W-1:0] BH_LVL_LO = 3'd2;
    localparam logic [BEHAV_W-1:0] BH_RISE   = 3'd3;
    localparam logic [BEHAV_W-1:0] BH_FALL   = 3'd4;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } line_state_e;

    function automatic logic behav_valid(input logic [BEHAV_W-1:0] b);
        return (b == BH_LVL_HI) || (b == BH_LVL_LO) ||
               (b == BH_RISE)   || (b == BH_FALL);
    endfunction

    function automatic logic behav_is_edge(input logic [BEHAV_W-1:0] b);
        return (b == BH_RISE) || (b == BH_FALL);
    endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= 1'b0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/trig_ref_align.sv
module trig_ref_align #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic [NUM_SRC-1:0] synced,
    output logic [NUM_SRC-1:0] held
);

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_hold
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        held[i] <= 1'b0;
                else if (ref_tick) held[i] <= synced[i];
            end
        end
    endgenerate

endmodule

// File: rtl/trig_src_path.sv
module trig_src_path #(
    parameter int                     NUM_SRC     = 2,
    parameter logic [NUM_SRC-1:0]     FORCE_ALIGN = 2'b10,
    localparam int                    SEL_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] synced,
    input  logic [NUM_SRC-1:0] held,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               io_align,
    output logic               line
);

    logic [NUM_SRC-1:0] aligned_en;
    logic [NUM_SRC-1:0] per_src;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            if (i == 0) begin : g_io
                assign aligned_en[i] = FORCE_ALIGN[i] | io_align;
            end else begin : g_fixed
                assign aligned_en[i] = FORCE_ALIGN[i];
            end
            assign per_src[i] = aligned_en[i] ? held[i] : synced[i];
        end
    endgenerate

    always_comb begin
        line = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_sel == SEL_W'(i)) line = per_src[i];
        end
    end

endmodule

// File: rtl/trig_behav_fsm.sv
module trig_behav_fsm
    import trig_cond_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line,
    input  logic [BEHAV_W-1:0] behav,
    output logic               trig
);

    line_state_e state_q;
    line_state_e state_d;
    logic        trig_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions: arm, rise, fall, disarm
    always_comb begin
        state_d = state_q;
        if (!behav_valid(behav)) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = line ? ST_HIGH : ST_LOW;
                ST_LOW:  state_d = line ? ST_HIGH : ST_LOW;
                ST_HIGH: state_d = line ? ST_HIGH : ST_LOW;
            endcase
        end
    end

    // output decode
    always_comb begin
        case (behav)
            BH_LVL_HI: trig_d = line;
            BH_LVL_LO: trig_d = !line;
            BH_RISE:   trig_d = (state_q == ST_LOW)  && line;
            BH_FALL:   trig_d = (state_q == ST_HIGH) && !line;
            default:   trig_d = 1'b0;
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= trig_d;
    end

endmodule

// File: rtl/trig_cond.sv
module trig_cond
    import trig_cond_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [1:0] FORCE_ALIGN = 2'b10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_line,
    input  logic               bp_line,
    input  logic               ref_tick,
    input  logic               src_sel,
    input  logic               io_align,
    input  logic [BEHAV_W-1:0] behav,
    output logic               trig_out
);

    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0] raw;
    logic [NUM_SRC-1:0] synced;
    logic [NUM_SRC-1:0] held;
    logic               cond_line;
    logic               bp_held;

    assign raw     = {bp_line, io_line};
    assign bp_held = held[1];

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
            trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .d_async (raw[i]),
                .q_sync  (synced[i])
            );
        end
    endgenerate

    trig_ref_align #(.NUM_SRC(NUM_SRC)) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .synced   (synced),
        .held     (held)
    );

    trig_src_path #(.NUM_SRC(NUM_SRC), .FORCE_ALIGN(FORCE_ALIGN)) u_path (
        .synced   (synced),
        .held     (held),
        .src_sel  (src_sel),
        .io_align (io_align),
        .line     (cond_line)
    );

    trig_behav_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (cond_line),
        .behav (behav),
        .trig  (trig_out)
    );

endmodule

// File: rtl/trig_cond_chk.sv
module trig_cond_chk
    import trig_cond_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ref_tick,
    input logic [BEHAV_W-1:0] behav,
    input logic               cond_line,
    input logic               bp_held,
    input logic               trig_out
);

    always @(posedge clk) begin
        if (!rst_n) AST_RESET_LOW: assert (trig_out == 1'b0); // R10
    end

    AST_BP_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ref_tick)) |-> $stable(bp_held)); // R3

    AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(behav) == BH_LVL_HI) |-> (trig_out == $past(cond_line))); // R5

    AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(behav) == BH_LVL_LO) |-> (trig_out == !$past(cond_line))); // R6

    AST_RISE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && trig_out && $past(behav) == BH_RISE) |-> $past(cond_line)); // R7

    AST_FALL_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && trig_out && $past(behav) == BH_FALL) |-> !$past(cond_line)); // R8

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && behav_is_edge($past(behav)) && $stable(behav)) |=> !trig_out); // R7

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !behav_valid($past(behav))) |-> !trig_out); // R9

    AST_NO_ARM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && behav_is_edge($past(behav)) && !behav_valid($past(behav, 2))) |-> !trig_out); // R10

endmodule

bind trig_cond trig_cond_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .behav     (behav),
    .cond_line (cond_line),
    .bp_held   (bp_held),
    .trig_out  (trig_out)
);

// File: tb/trig_cond_test.sv
module trig_cond_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_line = 1'b1;
    logic       bp_line = 1'b0;
    logic       ref_tick = 1'b0;
    logic       src_sel = 1'b0;
    logic       io_align = 1'b0;
    logic [2:0] behav = 3'd1;
    logic       trig_out;

    int checks = 0;
    int fails = 0;
    int tick_cnt = 0;
    bit tick_auto = 1'b1;
    bit tick_force = 1'b0;

    always #2 clk = ~clk;

    trig_cond uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_line  (io_line),
        .bp_line  (bp_line),
        .ref_tick (ref_tick),
        .src_sel  (src_sel),
        .io_align (io_align),
        .behav    (behav),
        .trig_out (trig_out)
    );

    // {src, align, behav[2:0], l0, l1, final, count[3:0], check_count}
    localparam int NV = 16;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0},
        {1'b0, 1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0},
        {1'b0, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0, 4'd1, 1'b1},
        {1'b0, 1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 4'd1, 1'b1},
        {1'b0, 1'b1, 3'd3, 1'b0, 1'b1, 1'b0, 4'd1, 1'b1},
        {1'b0, 1'b1, 3'd1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0},
        {1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0},
        {1'b1, 1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0},
        {1'b1, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0, 4'd1, 1'b1},
        {1'b1, 1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 4'd1, 1'b1},
        {1'b0, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1},
        {1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1},
        {1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1},
        {1'b0, 1'b0, 3'd5, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1},
        {1'b0, 1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1},
        {1'b1, 1'b0, 3'd6, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1}
    };

    task automatic cyc();
        @(posedge clk);
        #1;
        tick_cnt++;
        ref_tick = tick_force || (tick_auto && (tick_cnt % 5 == 0));
        @(negedge clk);
    endtask

    task automatic cycn(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic expect_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: trig_out=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic expect_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: pulse count=%0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string req_tag(input logic [2:0] b);
        case (b)
            3'd1:    return "R5";
            3'd2:    return "R6";
            3'd3:    return "R7";
            3'd4:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic drive_sel(input logic s, input logic l);
        if (s) begin bp_line = l; io_line = !l; end
        else   begin io_line = l; bp_line = !l; end
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int cnt;
        string tag;
        // R10: reset state
        cycn(3);
        expect_bit("R10 reset low", trig_out, 1'b0);
        rst_n = 1'b1;
        cycn(2);

        // vector table walk (R1 plus behaviour requirement)
        for (int v = 0; v < NV; v++) begin
            logic        s, a, l0, l1, fin, chk;
            logic [2:0]  b;
            logic [3:0]  c;
            {s, a, b, l0, l1, fin, c, chk} = VEC[v];
            tag = $sformatf("%s R1 vec%0d src=%0d", req_tag(b), v, s);
            src_sel = s; io_align = a; behav = b;
            drive_sel(s, l0);
            cycn(15);
            drive_sel(s, l1);
            cnt = 0;
            for (int k = 0; k < 20; k++) begin
                cyc();
                if (trig_out) cnt++;
            end
            if (chk) expect_int(tag, cnt, int'(c));
            expect_bit(tag, trig_out, fin);
        end

        // R2: unaligned front-panel latency of three edges
        src_sel = 1'b0; io_align = 1'b0; behav = 3'd1;
        io_line = 1'b0;
        cycn(8);
        io_line = 1'b1;
        cyc();
        expect_bit("R2 edge1", trig_out, 1'b0);
        cyc();
        expect_bit("R2 edge2", trig_out, 1'b0);
        cyc();
        expect_bit("R2 edge3", trig_out, 1'b1);

        // R4: aligned front-panel path waits for the tick; tick coincident with arrival
        io_align = 1'b1;
        io_line = 1'b0;
        cycn(12);
        tick_auto = 1'b0;
        cycn(2);
        io_line = 1'b1;
        cycn(10);
        expect_bit("R4 no tick, no change", trig_out, 1'b0);
        io_line = 1'b0;
        cycn(4);
        io_line = 1'b1;
        cyc();
        tick_force = 1'b1;
        cyc();
        tick_force = 1'b0;
        cyc();
        expect_bit("R4 capture edge", trig_out, 1'b0);
        cyc();
        expect_bit("R4 one edge after tick", trig_out, 1'b1);

        // R3: backplane path is aligned even with io_align low
        tick_auto = 1'b1;
        src_sel = 1'b1; io_align = 1'b0; behav = 3'd1;
        bp_line = 1'b0;
        cycn(12);
        tick_auto = 1'b0;
        cycn(2);
        bp_line = 1'b1;
        cycn(10);
        expect_bit("R3 backplane waits for tick", trig_out, 1'b0);
        tick_force = 1'b1;
        cyc();
        tick_force = 1'b0;
        cycn(2);
        expect_bit("R3 backplane after tick", trig_out, 1'b1);
        tick_auto = 1'b1;

        // R10: arming an edge code onto a line already high gives no pulse
        src_sel = 1'b0; io_align = 1'b0; behav = 3'd0;
        io_line = 1'b1;
        cycn(8);
        behav = 3'd3;
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            cyc();
            if (trig_out) cnt++;
        end
        expect_int("R10 no pulse on arm", cnt, 0);

        // R7: repeated rising edges, one pulse each
        io_line = 1'b0;
        cycn(6);
        cnt = 0;
        for (int r = 0; r < 3; r++) begin
            io_line = 1'b1;
            for (int k = 0; k < 4; k++) begin cyc(); if (trig_out) cnt++; end
            io_line = 1'b0;
            for (int k = 0; k < 4; k++) begin cyc(); if (trig_out) cnt++; end
        end
        cycn(4);
        expect_int("R7 three rises", cnt, 3);

        // R8: repeated falling edges, one pulse each
        behav = 3'd4;
        cycn(6);
        cnt = 0;
        for (int r = 0; r < 2; r++) begin
            io_line = 1'b1;
            for (int k = 0; k < 4; k++) begin cyc(); if (trig_out) cnt++; end
            io_line = 1'b0;
            for (int k = 0; k < 4; k++) begin cyc(); if (trig_out) cnt++; end
        end
        cycn(4);
        expect_int("R8 two falls", cnt, 2);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule